// File: doc/BRIEF.md
# Cache RAM Error Reporting Controller

This block gathers error reports from a set of cache RAM checkers and turns them into the responses the rest of the core needs. Each checker sits on one array, which is an L1 data, L2 data, L2 tag or duplicate L1 tag array. When it detects a fault it presents a one-cycle report. The report says whether the fault was corrected or is uncorrectable. It also gives the kind of access that found the fault, plus the set index and way. The block turns these reports into four results: performance event pulses, a captured syndrome for software, per-requester precise abort requests, and a sticky active-low interrupt.

The response depends on the array and the access. An uncorrectable fault in L2 data found by a fetch, table walk or load aborts the requester precisely. An uncorrectable fault in a data array found while a line leaves the cache cannot be tied to an instruction, so it raises the interrupt. The same holds for any uncorrectable tag fault. The interrupt stays asserted until software writes 0 to the asynchronous-error bit through the register write port. Reports are accepted unconditionally. The report interface carries a valid qualifier with no ready, because a checker cannot stall and no back-pressure is applied. The register write port is a plain single-cycle strobe.

Top module: `mer_report`

## Requirements
- R1: In the cycle after any cycle that carries at least one valid corrected report, `evt_corr_o` is 1 for exactly one cycle. It is 0 after a cycle with no corrected report.
- R2: In the cycle after any cycle that carries at least one valid uncorrectable report, `evt_fatal_o` is 1 for exactly one cycle. It is 0 after a cycle with no uncorrectable report.
- R3: When several reports arrive in one cycle, exactly one is captured into the syndrome. An uncorrectable report beats a corrected one, and among reports of equal severity the lowest source index wins. `syn_ram_o` holds the winning source index.
- R4: A valid syndrome is overwritten only when a new uncorrectable report replaces a held corrected one. A later corrected report, or any report while an uncorrectable one is held, leaves all syndrome fields unchanged.
- R5: A write with `csr_addr_i`=1 clears `syn_valid_o` on the next cycle. If a report arrives in the same cycle, that report is captured and the syndrome stays valid.
- R6: Source kinds are fixed by parameter, by default 0=L1 data, 1=L2 data, 2=L2 tag and 3=duplicate tag. Access codes are 0=fetch, 1=walk, 2=load, 3=store, 4=natural eviction, 5=maintenance eviction, 6=snoop eviction and 7=other. An uncorrectable L2 data report with access 0, 1 or 2 sets that source's bit of `abort_o` for one cycle on the next cycle. `abort_pf_o` is set only for access 0. No other report aborts.
- R7: An uncorrectable L1 or L2 data report with access 4, 5 or 6 drives `irq_n_o` low from the next cycle. Corrected reports and other access codes on data arrays leave it high.
- R8: An uncorrectable report from an L2 tag or duplicate tag source drives `irq_n_o` low from the next cycle, whatever the access code.
- R9: `irq_n_o` stays low until a write with `csr_addr_i`=0 and `csr_bit_i`=0. That write releases it on the next cycle. Writing `csr_bit_i`=1 has no effect, and a new qualifying error in the same cycle as the clear keeps it low.
- R10: Repeated reports of the same location are not merged. Every report cycle produces its own event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_vld_i | input | NUM_SRC | Per-source report valid |
| err_fatal_i | input | NUM_SRC | Per-source uncorrectable flag |
| err_acc_i | input | 3*NUM_SRC | Per-source access code |
| err_idx_i | input | IDX_W*NUM_SRC | Per-source set index |
| err_way_i | input | WAY_W*NUM_SRC | Per-source way |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | 1 | 0 = control, 1 = syndrome clear |
| csr_bit_i | input | 1 | Written value of the asynchronous-error bit |
| evt_corr_o | output | 1 | Corrected error event pulse |
| evt_fatal_o | output | 1 | Uncorrectable error event pulse |
| abort_o | output | NUM_SRC | Per-requester precise abort request |
| abort_pf_o | output | NUM_SRC | Abort is a prefetch abort |
| irq_n_o | output | 1 | Sticky active-low error interrupt |
| syn_valid_o | output | 1 | Syndrome holds an error |
| syn_fatal_o | output | 1 | Held error is uncorrectable |
| syn_ram_o | output | SEL_W | Source index of the held error |
| syn_idx_o | output | IDX_W | Set index of the held error |
| syn_way_o | output | WAY_W | Way of the held error |

## Verification
Each result comes from a single register stage. Event pulses, abort requests, syndrome updates and interrupt changes all become visible in the cycle after the report or register write. Each directed scenario drives its inputs just after a rising edge and checks the outputs 1 ns after the following rising edge. It then removes the stimulus and checks again one edge later. The second check confirms that pulses last one cycle and that the interrupt and syndrome hold their values. Same-cycle collisions are driven within a single stimulus cycle: several sources at once, and a clear arriving together with a new error.

// File: rtl/mer_pkg.sv
package mer_pkg;
  // source array kinds
  localparam logic [1:0] RK_L1D  = 2'd0;
  localparam logic [1:0] RK_L2D  = 2'd1;
  localparam logic [1:0] RK_L2T  = 2'd2;
  localparam logic [1:0] RK_DUPT = 2'd3;

  // access codes
  localparam int unsigned ACC_W = 3;
  localparam logic [ACC_W-1:0] ACC_FETCH  = 3'd0;
  localparam logic [ACC_W-1:0] ACC_WALK   = 3'd1;
  localparam logic [ACC_W-1:0] ACC_LOAD   = 3'd2;
  localparam logic [ACC_W-1:0] ACC_STORE  = 3'd3;
  localparam logic [ACC_W-1:0] ACC_EV_NAT = 3'd4;
  localparam logic [ACC_W-1:0] ACC_EV_CMO = 3'd5;
  localparam logic [ACC_W-1:0] ACC_EV_SNP = 3'd6;
  localparam logic [ACC_W-1:0] ACC_OTHER  = 3'd7;

  function automatic logic is_evict(input logic [ACC_W-1:0] a);
    return (a == ACC_EV_NAT) || (a == ACC_EV_CMO) || (a == ACC_EV_SNP);
  endfunction

  function automatic logic is_sync(input logic [ACC_W-1:0] a);
    return (a == ACC_FETCH) || (a == ACC_WALK) || (a == ACC_LOAD);
  endfunction
endpackage

// File: rtl/mer_classify.sv
module mer_classify
  import mer_pkg::*;
#(
  parameter logic [1:0] KIND = RK_L1D
) (
  input  logic             vld_i,
  input  logic             fatal_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             abort_o,
  output logic             abort_pf_o,
  output logic             irq_set_o
);
  logic unc;
  logic data_kind;
  logic tag_kind;

  assign unc       = vld_i && fatal_i;
  assign data_kind = (KIND == RK_L1D) || (KIND == RK_L2D);
  assign tag_kind  = (KIND == RK_L2T) || (KIND == RK_DUPT);

  always_comb begin
    abort_o    = 1'b0;
    abort_pf_o = 1'b0;
    irq_set_o  = 1'b0;
    if (unc) begin
      if (KIND == RK_L2D && is_sync(acc_i)) begin
        abort_o    = 1'b1;
        abort_pf_o = (acc_i == ACC_FETCH);
      end
      if (data_kind && is_evict(acc_i)) irq_set_o = 1'b1;
      if (tag_kind) irq_set_o = 1'b1;
    end
  end
endmodule

// File: rtl/mer_arbiter.sv
module mer_arbiter #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vld_i,
  input  logic [N-1:0]     fatal_i,
  output logic             win_vld_o,
  output logic             win_fatal_o,
  output logic [SEL_W-1:0] win_sel_o
);
  logic [N-1:0] unc_vec;
  assign unc_vec = vld_i & fatal_i;

  always_comb begin
    win_vld_o   = |vld_i;
    win_fatal_o = |unc_vec;
    win_sel_o   = '0;
    // scan downwards so that the lowest qualifying index is kept
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_i[i] && (fatal_i[i] || !win_fatal_o)) win_sel_o = SEL_W'(i);
    end
  end
endmodule

// File: rtl/mer_syndrome.sv
module mer_syndrome #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned IDX_W = 12,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_vld_i,
  input  logic             cap_fatal_i,
  input  logic [SEL_W-1:0] cap_ram_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  logic [WAY_W-1:0] cap_way_i,
  input  logic             clr_i,
  output logic             valid_o,
  output logic             fatal_o,
  output logic [SEL_W-1:0] ram_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [WAY_W-1:0] way_o
);
  logic take;
  assign take = cap_vld_i && (!valid_o || (cap_fatal_i && !fatal_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fatal_o <= 1'b0;
      ram_o   <= '0;
      idx_o   <= '0;
      way_o   <= '0;
    end else if (take) begin
      valid_o <= 1'b1;
      fatal_o <= cap_fatal_i;
      ram_o   <= cap_ram_i;
      idx_o   <= cap_idx_i;
      way_o   <= cap_way_i;
    end else if (clr_i && !cap_vld_i) begin
      valid_o <= 1'b0;
      fatal_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mer_irq.sv
module mer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ctl_wr_i,
  input  logic ctl_bit_i,
  output logic irq_n_o
);
  logic pend_q;
  logic clr;

  assign clr = ctl_wr_i && !ctl_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= set_i || (pend_q && !clr);
  end

  assign irq_n_o = !pend_q;
endmodule

// File: rtl/mer_report.sv
module mer_report
  import mer_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = 12,
  parameter int unsigned WAY_W   = 2,
  parameter logic [2*NUM_SRC-1:0] SRC_KINDS = {RK_DUPT, RK_L2T, RK_L2D, RK_L1D},
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       err_vld_i,
  input  logic [NUM_SRC-1:0]       err_fatal_i,
  input  logic [ACC_W*NUM_SRC-1:0] err_acc_i,
  input  logic [IDX_W*NUM_SRC-1:0] err_idx_i,
  input  logic [WAY_W*NUM_SRC-1:0] err_way_i,
  input  logic                     csr_wr_i,
  input  logic                     csr_addr_i,
  input  logic                     csr_bit_i,
  output logic                     evt_corr_o,
  output logic                     evt_fatal_o,
  output logic [NUM_SRC-1:0]       abort_o,
  output logic [NUM_SRC-1:0]       abort_pf_o,
  output logic                     irq_n_o,
  output logic                     syn_valid_o,
  output logic                     syn_fatal_o,
  output logic [SEL_W-1:0]         syn_ram_o,
  output logic [IDX_W-1:0]         syn_idx_o,
  output logic [WAY_W-1:0]         syn_way_o
);
  logic [NUM_SRC-1:0] abort_d;
  logic [NUM_SRC-1:0] abort_pf_d;
  logic [NUM_SRC-1:0] irq_vec;

  // per-source response policy
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    mer_classify #(.KIND(SRC_KINDS[2*g +: 2])) u_cls (
      .vld_i      (err_vld_i[g]),
      .fatal_i    (err_fatal_i[g]),
      .acc_i      (err_acc_i[ACC_W*g +: ACC_W]),
      .abort_o    (abort_d[g]),
      .abort_pf_o (abort_pf_d[g]),
      .irq_set_o  (irq_vec[g])
    );
  end

  // one report per cycle for the syndrome
  logic             win_vld;
  logic             win_fatal;
  logic [SEL_W-1:0] win_sel;

  mer_arbiter #(.N(NUM_SRC), .SEL_W(SEL_W)) u_arb (
    .vld_i       (err_vld_i),
    .fatal_i     (err_fatal_i),
    .win_vld_o   (win_vld),
    .win_fatal_o (win_fatal),
    .win_sel_o   (win_sel)
  );

  logic [IDX_W-1:0] win_idx;
  logic [WAY_W-1:0] win_way;
  assign win_idx = err_idx_i[win_sel*IDX_W +: IDX_W];
  assign win_way = err_way_i[win_sel*WAY_W +: WAY_W];

  mer_syndrome #(.SEL_W(SEL_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_syn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_vld_i   (win_vld),
    .cap_fatal_i (win_fatal),
    .cap_ram_i   (win_sel),
    .cap_idx_i   (win_idx),
    .cap_way_i   (win_way),
    .clr_i       (csr_wr_i && csr_addr_i),
    .valid_o     (syn_valid_o),
    .fatal_o     (syn_fatal_o),
    .ram_o       (syn_ram_o),
    .idx_o       (syn_idx_o),
    .way_o       (syn_way_o)
  );

  mer_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (|irq_vec),
    .ctl_wr_i  (csr_wr_i && !csr_addr_i),
    .ctl_bit_i (csr_bit_i),
    .irq_n_o   (irq_n_o)
  );

  // event pulses and abort requests, one register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_corr_o  <= 1'b0;
      evt_fatal_o <= 1'b0;
      abort_o     <= '0;
      abort_pf_o  <= '0;
    end else begin
      evt_corr_o  <= |(err_vld_i & ~err_fatal_i);
      evt_fatal_o <= |(err_vld_i & err_fatal_i);
      abort_o     <= abort_d;
      abort_pf_o  <= abort_pf_d;
    end
  end
endmodule

module mer_report_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned IDX_W   = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] err_vld_i,
  input logic [NUM_SRC-1:0] err_fatal_i,
  input logic               csr_wr_i,
  input logic               csr_addr_i,
  input logic               csr_bit_i,
  input logic               evt_corr_o,
  input logic               evt_fatal_o,
  input logic [NUM_SRC-1:0] abort_o,
  input logic               irq_n_o,
  input logic               syn_valid_o,
  input logic               syn_fatal_o,
  input logic [IDX_W-1:0]   syn_idx_o
);
  // R1
  corr_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(err_vld_i & ~err_fatal_i)) |=> evt_corr_o);
  // R2
  fatal_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(err_vld_i & err_fatal_i)) |=> !evt_fatal_o);
  // R6
  abort_needs_fatal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_o) |-> evt_fatal_o);
  // R9
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_n_o && !(csr_wr_i && !csr_addr_i && !csr_bit_i)) |=> !irq_n_o);
  // R4
  fatal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_valid_o && syn_fatal_o && !(csr_wr_i && csr_addr_i))
      |=> (syn_valid_o && syn_fatal_o && $stable(syn_idx_o)));
  // R5
  syn_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_vld_i) |=> syn_valid_o);
endmodule

bind mer_report mer_report_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_vld_i   (err_vld_i),
  .err_fatal_i (err_fatal_i),
  .csr_wr_i    (csr_wr_i),
  .csr_addr_i  (csr_addr_i),
  .csr_bit_i   (csr_bit_i),
  .evt_corr_o  (evt_corr_o),
  .evt_fatal_o (evt_fatal_o),
  .abort_o     (abort_o),
  .irq_n_o     (irq_n_o),
  .syn_valid_o (syn_valid_o),
  .syn_fatal_o (syn_fatal_o),
  .syn_idx_o   (syn_idx_o)
);

// File: tb/mer_report_tb.sv
`timescale 1ns/1ps
module mer_report_tb_top;
  localparam int N = 4;
  localparam int IW = 12;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  vld, fat;
  logic [3*N-1:0] acc;
  logic [IW*N-1:0] idx;
  logic [WW*N-1:0] way;
  logic csr_wr, csr_addr, csr_bit;
  logic evt_c, evt_f, irq_n, s_vld, s_fat;
  logic [N-1:0] abt, abt_pf;
  logic [1:0] s_ram;
  logic [IW-1:0] s_idx;
  logic [WW-1:0] s_way;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mer_report dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .err_vld_i(vld), .err_fatal_i(fat), .err_acc_i(acc),
    .err_idx_i(idx), .err_way_i(way),
    .csr_wr_i(csr_wr), .csr_addr_i(csr_addr), .csr_bit_i(csr_bit),
    .evt_corr_o(evt_c), .evt_fatal_o(evt_f),
    .abort_o(abt), .abort_pf_o(abt_pf), .irq_n_o(irq_n),
    .syn_valid_o(s_vld), .syn_fatal_o(s_fat), .syn_ram_o(s_ram),
    .syn_idx_o(s_idx), .syn_way_o(s_way)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    vld = '0; fat = '0; acc = '0; idx = '0; way = '0;
    csr_wr = 1'b0; csr_addr = 1'b0; csr_bit = 1'b0;
  endtask

  task automatic add(int s, bit f, logic [2:0] a, logic [11:0] ix, logic [1:0] w);
    vld[s] = 1'b1;
    fat[s] = f;
    acc[3*s +: 3] = a;
    idx[IW*s +: IW] = ix;
    way[WW*s +: WW] = w;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic csr(bit addr, bit b);
    csr_wr = 1'b1; csr_addr = addr; csr_bit = b;
  endtask

  task automatic syn_clear();
    idle_in(); csr(1'b1, 1'b0); cyc(); idle_in();
  endtask

  task automatic irq_clear();
    idle_in(); csr(1'b0, 1'b0); cyc(); idle_in();
  endtask

  task automatic t_reset();
    chk("R1", "evt_corr after reset", evt_c, 0);
    chk("R2", "evt_fatal after reset", evt_f, 0);
    chk("R9", "irq_n after reset", irq_n, 1);
    chk("R5", "syn_valid after reset", s_vld, 0);
    chk("R6", "abort after reset", abt, 0);
  endtask

  task automatic t_corrected();
    idle_in(); add(0, 0, 3'd2, 12'h123, 2'd1); cyc(); idle_in();
    chk("R1", "evt_corr on corrected", evt_c, 1);
    chk("R2", "evt_fatal on corrected", evt_f, 0);
    chk("R6", "no abort on corrected", abt, 0);
    chk("R3", "syn idx", s_idx, 12'h123);
    chk("R3", "syn way", s_way, 1);
    chk("R3", "syn ram", s_ram, 0);
    chk("R4", "syn fatal", s_fat, 0);
    cyc();
    chk("R1", "evt_corr single cycle", evt_c, 0);
    add(0, 0, 3'd2, 12'h123, 2'd1); cyc(); idle_in();
    chk("R10", "repeat report pulses again", evt_c, 1);
    chk("R4", "repeat keeps syndrome", s_idx, 12'h123);
    cyc();
  endtask

  task automatic t_hold();
    add(3, 0, 3'd2, 12'h222, 2'd2); cyc(); idle_in();
    chk("R4", "corrected over corrected ignored", s_idx, 12'h123);
    add(1, 1, 3'd3, 12'h456, 2'd3); cyc(); idle_in();
    chk("R4", "fatal replaces corrected idx", s_idx, 12'h456);
    chk("R4", "fatal replaces corrected flag", s_fat, 1);
    chk("R3", "ram of replacing report", s_ram, 1);
    chk("R2", "evt_fatal on store fatal", evt_f, 1);
    chk("R6", "store does not abort", abt, 0);
    chk("R7", "store does not interrupt", irq_n, 1);
    add(0, 1, 3'd2, 12'h789, 2'd0); cyc(); idle_in();
    chk("R4", "fatal over fatal ignored", s_idx, 12'h456);
    chk("R6", "L1 data load no abort", abt, 0);
    chk("R7", "L1 data load no irq", irq_n, 1);
    cyc();
  endtask

  task automatic t_syn_clear();
    syn_clear();
    chk("R5", "syndrome cleared", s_vld, 0);
    csr(1'b1, 1'b0); add(3, 0, 3'd7, 12'h0AA, 2'd0); cyc(); idle_in();
    chk("R5", "capture beats clear valid", s_vld, 1);
    chk("R5", "capture beats clear idx", s_idx, 12'h0AA);
    syn_clear();
  endtask

  task automatic t_arbitration();
    add(0, 0, 3'd2, 12'h010, 2'd0);
    add(1, 0, 3'd2, 12'h011, 2'd1);
    add(3, 0, 3'd2, 12'h013, 2'd3);
    cyc(); idle_in();
    chk("R3", "lowest corrected wins", s_idx, 12'h010);
    chk("R2", "no fatal event", evt_f, 0);
    syn_clear();
    add(0, 0, 3'd2, 12'h020, 2'd0);
    add(1, 1, 3'd3, 12'h021, 2'd1);
    add(3, 1, 3'd3, 12'h023, 2'd3);
    cyc(); idle_in();
    chk("R3", "lowest fatal wins ram", s_ram, 1);
    chk("R3", "lowest fatal wins idx", s_idx, 12'h021);
    chk("R1", "mixed cycle corr event", evt_c, 1);
    chk("R2", "mixed cycle fatal event", evt_f, 1);
    chk("R8", "dup tag fatal irq", irq_n, 0);
    irq_clear(); syn_clear();
  endtask

  task automatic t_abort();
    add(1, 1, 3'd0, 12'h001, 2'd0); cyc(); idle_in();
    chk("R6", "fetch abort", abt, 4'b0010);
    chk("R6", "fetch is prefetch abort", abt_pf, 4'b0010);
    chk("R7", "fetch abort no irq", irq_n, 1);
    cyc();
    chk("R6", "abort single cycle", abt, 0);
    add(1, 1, 3'd1, 12'h002, 2'd0); cyc(); idle_in();
    chk("R6", "walk abort", abt, 4'b0010);
    chk("R6", "walk data abort", abt_pf, 0);
    add(1, 1, 3'd2, 12'h003, 2'd0); cyc(); idle_in();
    chk("R6", "load abort", abt, 4'b0010);
    chk("R6", "load data abort", abt_pf, 0);
    add(1, 0, 3'd2, 12'h004, 2'd0); cyc(); idle_in();
    chk("R6", "corrected load no abort", abt, 0);
    add(1, 1, 3'd4, 12'h005, 2'd0); cyc(); idle_in();
    chk("R6", "evict no abort", abt, 0);
    chk("R7", "L2 data natural evict irq", irq_n, 0);
    irq_clear(); syn_clear();
  endtask

  task automatic t_evict_irq();
    add(0, 1, 3'd5, 12'h030, 2'd0); cyc(); idle_in();
    chk("R7", "L1 data maintenance evict irq", irq_n, 0);
    irq_clear();
    chk("R9", "irq released", irq_n, 1);
    add(1, 1, 3'd6, 12'h031, 2'd0); cyc(); idle_in();
    chk("R7", "L2 data snoop evict irq", irq_n, 0);
    irq_clear();
    add(0, 0, 3'd4, 12'h032, 2'd0); cyc(); idle_in();
    chk("R7", "corrected evict no irq", irq_n, 1);
    syn_clear();
  endtask

  task automatic t_tag_irq();
    add(2, 1, 3'd0, 12'h040, 2'd0); cyc(); idle_in();
    chk("R8", "L2 tag fetch irq", irq_n, 0);
    chk("R6", "tag fatal no abort", abt, 0);
    irq_clear();
    add(3, 1, 3'd3, 12'h041, 2'd0); cyc(); idle_in();
    chk("R8", "dup tag store irq", irq_n, 0);
    irq_clear(); syn_clear();
  endtask

  task automatic t_irq_clear();
    add(2, 1, 3'd7, 12'h050, 2'd0); cyc(); idle_in();
    chk("R8", "tag other irq", irq_n, 0);
    csr(1'b0, 1'b1); cyc(); idle_in();
    chk("R9", "write 1 no effect", irq_n, 0);
    cyc();
    chk("R9", "irq sticky idle", irq_n, 0);
    csr(1'b1, 1'b0); cyc(); idle_in();
    chk("R9", "syndrome clear keeps irq", irq_n, 0);
    irq_clear();
    chk("R9", "write 0 releases", irq_n, 1);
    add(2, 1, 3'd7, 12'h051, 2'd0); cyc(); idle_in();
    csr(1'b0, 1'b0); add(3, 1, 3'd2, 12'h052, 2'd0); cyc(); idle_in();
    chk("R9", "new error with clear stays low", irq_n, 0);
    cyc();
    chk("R9", "still low after collision", irq_n, 0);
    irq_clear();
    chk("R9", "final release", irq_n, 1);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL all watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    t_reset();
    t_corrected();
    t_hold();
    t_syn_clear();
    t_arbitration();
    t_abort();
    t_evict_irq();
    t_tag_irq();
    t_irq_clear();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule